// File: doc/BRIEF.md
# Iterative 64-bit Lightweight Block Cipher Core

This core encrypts or decrypts one 64-bit block under an 80-bit key. It uses a substitution-permutation network of 31 rounds. Each round adds a round key with XOR, passes every nibble through a 4-bit substitution box, and then moves the state bits through a fixed wiring permutation. The core runs one round per clock cycle and builds each round key from an 80-bit key register as it goes, so no key table is stored.

A caller presents the block, the key and the direction, then raises `start_i` for one cycle while the core is idle. `busy_o` stays high for the whole operation. `done_o` pulses for one cycle when `block_o` carries the result. `block_o` keeps that value until the next result arrives.

Decryption reuses the same key register. It first steps the schedule forward to reach the final key, then walks it back one round per cycle while it undoes the rounds. A decryption therefore takes twice as many cycles as an encryption.

Top module: `spn64_core`

## Requirements
- R1: Encryption works as follows. For rounds r = 1..31, the state is XORed with the top 64 bits of the key register. Each nibble v then becomes S(v), where S(0..F) = C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Bit i then moves to bit 16*(i mod 4) + i/4. After each round, the key register is rotated left by 61, its top nibble is replaced by S of itself, and r is XORed into bits 19..15. After round 31, the result is the state XOR the top 64 bits of the key register.
- R2: Decryption (`decrypt_i`=1) returns the block that encryption under the same key maps to the given input. This includes the all-zero and all-one keys and blocks.
- R3: An encryption raises `done_o` exactly 31 rising edges after the edge that accepted `start_i`.
- R4: A decryption raises `done_o` exactly 62 rising edges after the accepting edge.
- R5: `busy_o` is high from the edge after acceptance until `done_o` rises. `done_o` is high for exactly one cycle and never together with `busy_o`.
- R6: `start_i` is ignored while `busy_o` is high. The running result and its timing are unchanged.
- R7: After reset, `busy_o` and `done_o` are low and `block_o` is zero.
- R8: `block_o` changes only in the cycle in which `done_o` is high. Inputs are sampled only at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| decrypt_i | input | 1 | 1 selects decryption, 0 encryption |
| block_i | input | 64 | Plaintext or ciphertext |
| key_i | input | 80 | Cipher key |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| block_o | output | 64 | Result, held until next completion |

## Verification
The assertions assume that reset is applied before the first start, and that `start_i` is a plain level sampled at the clock edge. Under those conditions, latency, pulse shape and result-holding follow from the control state alone. The stimulus changes all inputs only on the falling edge. It scrambles `block_i`, `key_i` and `decrypt_i` right after each accepted start, which shows that only the accepting edge matters. It also raises `start_i` in the middle of a run. Random keys and blocks come from a fixed seed and are mixed with known all-zero and all-one vectors.

// File: rtl/spn64_pkg.sv
package spn64_pkg;
  localparam int unsigned BLK_W = 64;
  localparam int unsigned KEY_W = 80;
  localparam int unsigned NIB_N = BLK_W / 4;
  localparam int unsigned RC_W  = 5;
  localparam int unsigned RK_LO = KEY_W - BLK_W;

  typedef enum logic [1:0] {PH_IDLE, PH_ENC, PH_KFWD, PH_DEC} phase_e;

  function automatic logic [3:0] sbox4(input logic [3:0] v);
    case (v)
      4'h0: return 4'hC; 4'h1: return 4'h5; 4'h2: return 4'h6; 4'h3: return 4'hB;
      4'h4: return 4'h9; 4'h5: return 4'h0; 4'h6: return 4'hA; 4'h7: return 4'hD;
      4'h8: return 4'h3; 4'h9: return 4'hE; 4'hA: return 4'hF; 4'hB: return 4'h8;
      4'hC: return 4'h4; 4'hD: return 4'h7; 4'hE: return 4'h1; default: return 4'h2;
    endcase
  endfunction

  function automatic logic [3:0] sbox4_inv(input logic [3:0] v);
    case (v)
      4'h0: return 4'h5; 4'h1: return 4'hE; 4'h2: return 4'hF; 4'h3: return 4'h8;
      4'h4: return 4'hC; 4'h5: return 4'h1; 4'h6: return 4'h2; 4'h7: return 4'hD;
      4'h8: return 4'hB; 4'h9: return 4'h4; 4'hA: return 4'h6; 4'hB: return 4'h3;
      4'hC: return 4'h0; 4'hD: return 4'h7; 4'hE: return 4'h9; default: return 4'hA;
    endcase
  endfunction

  // Bit i goes to (16*i) mod 63; the top bit is fixed.
  function automatic logic [BLK_W-1:0] perm_fwd(input logic [BLK_W-1:0] b);
    logic [BLK_W-1:0] o;
    o = '0;
    for (int i = 0; i < BLK_W - 1; i++) o[(i * 16) % (BLK_W - 1)] = b[i];
    o[BLK_W-1] = b[BLK_W-1];
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] perm_inv(input logic [BLK_W-1:0] b);
    logic [BLK_W-1:0] o;
    o = '0;
    for (int i = 0; i < BLK_W - 1; i++) o[i] = b[(i * 16) % (BLK_W - 1)];
    o[BLK_W-1] = b[BLK_W-1];
    return o;
  endfunction

  function automatic logic [KEY_W-1:0] key_fwd(input logic [KEY_W-1:0] k,
                                                input logic [RC_W-1:0] rc);
    logic [KEY_W-1:0] t;
    t = {k[18:0], k[KEY_W-1:19]};
    t[KEY_W-1:KEY_W-4] = sbox4(t[KEY_W-1:KEY_W-4]);
    t[19:15] = t[19:15] ^ rc;
    return t;
  endfunction

  function automatic logic [KEY_W-1:0] key_bwd(input logic [KEY_W-1:0] k,
                                                input logic [RC_W-1:0] rc);
    logic [KEY_W-1:0] t;
    t = k;
    t[19:15] = t[19:15] ^ rc;
    t[KEY_W-1:KEY_W-4] = sbox4_inv(t[KEY_W-1:KEY_W-4]);
    return {t[60:0], t[KEY_W-1:61]};
  endfunction
endpackage

// File: rtl/spn64_keystep.sv
module spn64_keystep
  import spn64_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  input  logic [RC_W-1:0]  rc_i,
  output logic [KEY_W-1:0] fwd_o,
  output logic [KEY_W-1:0] bwd_o
);
  assign fwd_o = key_fwd(key_i, rc_i);
  assign bwd_o = key_bwd(key_i, rc_i);
endmodule

// File: rtl/spn64_round.sv
module spn64_round
  import spn64_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rk_i,
  input  logic             dec_i,
  output logic [BLK_W-1:0] next_o
);
  logic [BLK_W-1:0] mixed, sub_f, unperm, sub_i;

  assign mixed  = state_i ^ rk_i;
  assign unperm = perm_inv(state_i);

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    assign sub_f[4*g +: 4] = sbox4(mixed[4*g +: 4]);
    assign sub_i[4*g +: 4] = sbox4_inv(unperm[4*g +: 4]);
  end

  assign next_o = dec_i ? (sub_i ^ rk_i) : perm_fwd(sub_f);
endmodule

// File: rtl/spn64_ctrl.sv
module spn64_ctrl
  import spn64_pkg::*;
#(
  parameter int unsigned ROUNDS = 31,
  localparam int unsigned CW = $clog2(ROUNDS + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          decrypt_i,
  output phase_e        phase_o,
  output logic [CW-1:0] rnd_o,
  output logic          accept_o,
  output logic          last_o,
  output logic          fin_o,
  output logic          busy_o,
  output logic          done_o
);
  phase_e        phase_q;
  logic [CW-1:0] rnd_q;
  logic          done_q;

  assign accept_o = start_i && (phase_q == PH_IDLE);
  always_comb begin
    case (phase_q)
      PH_ENC, PH_KFWD: last_o = (rnd_q == CW'(ROUNDS));
      PH_DEC:          last_o = (rnd_q == CW'(1));
      default:         last_o = 1'b0;
    endcase
  end
  assign fin_o   = last_o && (phase_q == PH_ENC || phase_q == PH_DEC);
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
  assign phase_o = phase_q;
  assign rnd_o   = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_o;
      case (phase_q)
        PH_IDLE: if (accept_o) begin
          phase_q <= decrypt_i ? PH_KFWD : PH_ENC;
          rnd_q   <= CW'(1);
        end
        PH_ENC:  if (last_o) phase_q <= PH_IDLE; else rnd_q <= rnd_q + CW'(1);
        PH_KFWD: if (last_o) phase_q <= PH_DEC;  else rnd_q <= rnd_q + CW'(1);
        default: if (last_o) phase_q <= PH_IDLE; else rnd_q <= rnd_q - CW'(1);
      endcase
    end
  end
endmodule

// File: rtl/spn64_core.sv
module spn64_core
  import spn64_pkg::*;
#(
  parameter int unsigned ROUNDS = 31
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        decrypt_i,
  input  logic [63:0] block_i,
  input  logic [79:0] key_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [63:0] block_o
);
  localparam int unsigned CW = $clog2(ROUNDS + 1);

  phase_e           phase_w;
  logic [CW-1:0]    rnd_w;
  logic             accept_w, last_w, fin_w;
  logic [BLK_W-1:0] state_q, out_q, rnd_nxt, rk_w;
  logic [KEY_W-1:0] key_q, kf_w, kb_w;
  logic [RC_W-1:0]  rc_w;
  logic             in_dec;

  spn64_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
    .phase_o(phase_w), .rnd_o(rnd_w), .accept_o(accept_w), .last_o(last_w),
    .fin_o(fin_w), .busy_o(busy_o), .done_o(done_o)
  );

  assign rc_w   = RC_W'(rnd_w);
  assign in_dec = (phase_w == PH_DEC);

  spn64_keystep u_key (.key_i(key_q), .rc_i(rc_w), .fwd_o(kf_w), .bwd_o(kb_w));

  assign rk_w = in_dec ? kb_w[KEY_W-1:RK_LO] : key_q[KEY_W-1:RK_LO];

  spn64_round u_round (.state_i(state_q), .rk_i(rk_w), .dec_i(in_dec), .next_o(rnd_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      key_q   <= '0;
      out_q   <= '0;
    end else begin
      case (phase_w)
        PH_IDLE: if (accept_w) begin
          state_q <= block_i;
          key_q   <= key_i;
        end
        PH_ENC: begin
          state_q <= rnd_nxt;
          key_q   <= kf_w;
          if (last_w) out_q <= rnd_nxt ^ kf_w[KEY_W-1:RK_LO];
        end
        PH_KFWD: begin
          key_q <= kf_w;
          if (last_w) state_q <= state_q ^ kf_w[KEY_W-1:RK_LO];
        end
        default: begin
          state_q <= rnd_nxt;
          key_q   <= kb_w;
          if (last_w) out_q <= rnd_nxt;
        end
      endcase
    end
  end

  assign block_o = out_q;
endmodule

// File: rtl/spn64_chk.sv
module spn64_chk #(
  parameter int unsigned ROUNDS = 31
)(
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        decrypt_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [63:0] block_o,
  input logic        accept_w,
  input logic        fin_w
);
  logic [7:0] cyc_q;
  logic       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      mode_q <= 1'b0;
    end else if (accept_w) begin
      cyc_q  <= '0;
      mode_q <= decrypt_i;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 8'd1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R5
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R5
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !mode_q) |-> (cyc_q == 8'(ROUNDS))); // R3
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q) |-> (cyc_q == 8'(2 * ROUNDS))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !fin_w) |=> busy_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(block_o)); // R8
endmodule

bind spn64_core spn64_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
  .busy_o(busy_o), .done_o(done_o), .block_o(block_o),
  .accept_w(accept_w), .fin_w(fin_w)
);

// File: tb/tb_spn64_core.sv
`timescale 1ns/1ps
module tb_spn64_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        decrypt_i = 1'b0;
  logic [63:0] block_i = '0;
  logic [79:0] key_i = '0;
  logic        busy_o, done_o;
  logic [63:0] block_o;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  spn64_core dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
                  .block_i(block_i), .key_i(key_i), .busy_o(busy_o), .done_o(done_o),
                  .block_o(block_o));

  localparam logic [63:0] SB = 64'h2174_8FE3_DA09_B65C;

  function automatic logic [3:0] m_sb(input logic [3:0] v);
    return SB[4*v +: 4];
  endfunction

  function automatic logic [63:0] m_enc(input logic [63:0] p, input logic [79:0] k);
    logic [79:0] kr;
    logic [63:0] s, t;
    kr = k;
    s  = p;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kr[79:16];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = m_sb(s[4*n +: 4]);
      for (int i = 0; i < 64; i++) t[16*(i % 4) + i / 4] = s[i];
      s = t;
      kr = {kr[18:0], kr[79:19]};
      kr[79:76] = m_sb(kr[79:76]);
      kr[19:15] = kr[19:15] ^ 5'(r);
    end
    return s ^ kr[79:16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally raises start again mid-run with other data.
  task automatic run_op(input bit dec, input logic [63:0] b, input logic [79:0] k,
                        input int poke_at, output logic [63:0] res, output int lat,
                        output bit busy_ok, output bit pulse_ok);
    @(negedge clk);
    start_i = 1'b1; decrypt_i = dec; block_i = b; key_i = k;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; block_i = {$urandom, $urandom}; key_i = {$urandom, $urandom, $urandom};
    decrypt_i = ~dec;
    busy_ok = busy_o;
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_i = (lat == poke_at);
      if (!done_o && !busy_o) busy_ok = 1'b0;
      if (done_o) break;
    end
    start_i = 1'b0;
    res = block_o;
    if (busy_o) busy_ok = 1'b0;
    @(negedge clk);
    pulse_ok = !done_o && (block_o == res);
  endtask

  task automatic do_pair(input logic [63:0] p, input logic [79:0] k, input logic [63:0] ct_exp);
    logic [63:0] r; int lat; bit bok, pok;
    run_op(1'b0, p, k, 0, r, lat, bok, pok);
    chk(r == ct_exp, "R1 encrypt", r, ct_exp);
    chk(lat == 31, "R3 encrypt latency", 64'(lat), 64'd31);
    chk(bok && pok, "R5 busy/done shape", {62'd0, bok, pok}, 64'd3);
    run_op(1'b1, ct_exp, k, 0, r, lat, bok, pok);
    chk(r == p, "R2 decrypt", r, p);
    chk(lat == 62, "R4 decrypt latency", 64'(lat), 64'd62);
    chk(pok, "R8 result held after done", {63'd0, pok}, 64'd1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] p, r;
    logic [79:0] k;
    int lat; bit bok, pok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R7 reset flags", {62'd0, busy_o, done_o}, 64'd0);
    chk(block_o == 64'd0, "R7 reset result", block_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && block_o == 64'd0, "R7 idle after reset", block_o, 64'd0);

    // Directed corner vectors, with expected values checked against the bench model too.
    chk(m_enc('0, '0) == 64'h5579C1387B228445, "R1 model zero", m_enc('0, '0), 64'h5579C1387B228445);
    do_pair(64'h0, 80'h0, 64'h5579C1387B228445);
    do_pair(64'h0, {80{1'b1}}, 64'hE72C46C0F5945049);
    do_pair({64{1'b1}}, 80'h0, 64'hA112FFC72F68417B);
    do_pair({64{1'b1}}, {80{1'b1}}, 64'h3333DCD3213210D2);

    // R6: start raised mid-run in both directions
    p = 64'h0123_4567_89AB_CDEF; k = 80'h1357_9BDF_0246_8ACE_FFEE;
    run_op(1'b0, p, k, 5, r, lat, bok, pok);
    chk(r == m_enc(p, k), "R6 encrypt unaffected", r, m_enc(p, k));
    chk(lat == 31, "R6 encrypt timing kept", 64'(lat), 64'd31);
    run_op(1'b1, m_enc(p, k), k, 40, r, lat, bok, pok);
    chk(r == p, "R6 decrypt unaffected", r, p);
    chk(lat == 62, "R6 decrypt timing kept", 64'(lat), 64'd62);
    @(negedge clk);
    chk(!busy_o, "R6 no extra run started", {63'd0, busy_o}, 64'd0);

    for (int n = 0; n < 16; n++) begin
      p = {$urandom, $urandom};
      k = {$urandom, $urandom, $urandom};
      do_pair(p, k, m_enc(p, k));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule